// File: doc/BRIEF.md
# MSI Interrupt Remapping Unit

This unit sits between interrupt-generating devices and the interrupt fabric. It takes one message-signalled interrupt at a time. Each request carries a 64-bit address, a 32-bit data word and a 16-bit requester ID. Alongside the request come the two device-table words (word 2 and word 3) that an upstream stage has already fetched for that requester, and two flags: one says whether a device table exists at all, the other whether interrupt remapping is enabled for the whole system.

From these inputs the unit settles on one of three outcomes:

- **Pass:** the message leaves unchanged.
- **Remap:** the unit makes one read of a 32-bit remapping entry over a plain request/response memory port. It checks the entry and builds a new MSI address and data from the entry's fields.
- **Reject:** the request finishes with a target-abort or an error status.

Every accepted request produces exactly one response. That response carries the outgoing address, the outgoing data, the effective requester ID and a two-bit status.

Top module: `msi_remap_unit`

## Requirements
- R1: When the requester ID is 0xFFFF, the response requester ID is 0x00A0 (parameter `IOAPIC_RID`). Otherwise the response carries the request's own ID. This holds for every outcome.
- R2: If the device table is absent, or the remap-enable bit (device-table word 2, bit 0) is clear, the response has status ok (code 0), the request address and data unchanged, and no memory read. These two conditions take precedence over every later check.
- R3: If remapping is enabled for the device but global remapping is off, the status is error (code 2).
- R4: If remapping applies, global remapping is on, and address bits 63:32 are nonzero, the status is error.
- R5: The delivery mode is data bits 10:8. Mode 2 and the undefined modes 3 and 6 give error.
- R6: Modes 0 and 1 are steered by the two-bit control field in word 2, bits 2:1:
  - 0 gives target-abort (code 1).
  - 1 passes the message unchanged with status ok.
  - 2 starts a table lookup.
  - 3 gives error.
- R7: A lookup issues exactly one read, at address `{word2[51:6], 6'b0} + data[10:0]*4`. The read address holds steady while the read is not accepted.
- R8: The fetched entry is judged in this order, and the first failing check sets the status:
  - a memory error flag gives error;
  - entry bit 0 clear gives target-abort;
  - entry bit 7 set gives error;
  - entry bits 4:2 greater than 1 give error.
- R9: A good entry yields status ok. The address is 0xFEE00000 with entry bits 15:8 in address bits 19:12, entry bit 5 in address bit 3 and entry bit 6 in address bit 2; address bits 63:32 are zero. The data holds entry bits 23:16 in data bits 7:0 and entry bits 4:2 in data bits 10:8; all other data bits are zero.
- R10: Modes 4, 5 and 7 each need their own pass bit in word 3: bit 2 for mode 4, bit 0 for mode 5 and bit 1 for mode 7. They also need address bit 2 to be zero. If both hold, the message passes unchanged with status ok; otherwise the status is error. The control field plays no part for these modes.
- R11: Whenever the status is not ok, the response address and data are zero.
- R12: `req_ready` is high only while idle. `rsp_valid` is a single-cycle pulse, one per accepted request. A request held up while the unit is busy is taken only once the unit is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_addr | input | 64 | Incoming MSI address |
| req_data | input | 32 | Incoming MSI data |
| req_rid | input | 16 | Requester ID |
| dte_w2 | input | 64 | Device-table word 2 (enable, control field, table root) |
| dte_w3 | input | 64 | Device-table word 3 (per-type pass bits) |
| table_present | input | 1 | A device table is configured |
| remap_global_en | input | 1 | Interrupt remapping enabled system-wide |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the remapping entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Remapping entry word |
| mem_rsp_err | input | 1 | Read failed |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 64 | Outgoing MSI address |
| rsp_data | output | 32 | Outgoing MSI data |
| rsp_rid | output | 16 | Effective requester ID |
| rsp_status | output | 2 | 0 ok, 1 target-abort, 2 error |

## Verification
Two functions can coincide in one cycle: the unit issuing a response pulse, and a new request already waiting on the input. The bench provokes this by changing the request inputs during the response cycle while keeping `req_valid` high.

It then checks three things:
- the pulse still carries the first request's values;
- `req_ready` stays low during that cycle;
- the second request is taken only in the following idle cycle and produces its own correct response.

A related overlap is a read that memory holds back over several cycles. During that stall the bench checks that the read address stays steady and that only one read is counted.

// File: rtl/msi_remap_pkg.sv
package msi_remap_pkg;

  // Message geometry
  localparam int MSI_AW = 64;
  localparam int MSI_DW = 32;
  localparam int DTE_W  = 64;
  localparam int ENT_W  = 32;

  // Device-table word 2 fields
  localparam int W2_EN_BIT    = 0;
  localparam int W2_CTL_LSB   = 1;
  localparam int W2_ROOT_LSB  = 6;
  localparam int W2_ROOT_MSB  = 51;
  localparam int TBL_AW       = W2_ROOT_MSB + 1;

  // Device-table word 3 pass bits
  localparam int W3_INIT_BIT   = 0;
  localparam int W3_EXTINT_BIT = 1;
  localparam int W3_NMI_BIT    = 2;

  // MSI field positions
  localparam int DMODE_LSB    = 8;
  localparam int ADDR_DM_BIT  = 2;
  localparam int ADDR_RH_BIT  = 3;
  localparam int ADDR_DST_LSB = 12;
  localparam logic [11:0] MSI_WINDOW = 12'hFEE;

  // Delivery modes
  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_ARB    = 3'd1;
  localparam logic [2:0] DM_SMI    = 3'd2;
  localparam logic [2:0] DM_NMI    = 3'd4;
  localparam logic [2:0] DM_INIT   = 3'd5;
  localparam logic [2:0] DM_EXTINT = 3'd7;

  // Control field codes
  localparam logic [1:0] CTL_ABORT = 2'd0;
  localparam logic [1:0] CTL_PASS  = 2'd1;
  localparam logic [1:0] CTL_REMAP = 2'd2;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_ABORT = 2'd1,
    ST_ERROR = 2'd2
  } rsp_status_e;

  typedef enum logic [1:0] {
    ACT_PASS,
    ACT_FETCH,
    ACT_ABORT,
    ACT_ERROR
  } action_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_DONE
  } state_e;

  // Remapping entry, 32 bits, MSB first
  typedef struct packed {
    logic [7:0] rsvd_hi;
    logic [7:0] vector;
    logic [7:0] dest;
    logic       guest;
    logic       dest_mode;
    logic       redir;
    logic [2:0] itype;
    logic       rsvd_lo;
    logic       valid;
  } entry_t;

endpackage

// File: rtl/msi_remap_classify.sv
module msi_remap_classify
  import msi_remap_pkg::*;
#(
  parameter int               RID_W      = 16,
  parameter int               IDX_W      = 11,
  parameter logic [RID_W-1:0] IOAPIC_RID = 16'h00A0
) (
  input  logic [MSI_AW-1:0] msi_addr,
  input  logic [MSI_DW-1:0] msi_data,
  input  logic [RID_W-1:0]  rid,
  input  logic [DTE_W-1:0]  dte2,
  input  logic [DTE_W-1:0]  dte3,
  input  logic              table_present,
  input  logic              remap_global_en,
  output action_e           action,
  output logic [RID_W-1:0]  eff_rid,
  output logic [TBL_AW-1:0] entry_addr
);

  localparam logic [RID_W-1:0] INVALID_RID = '1;
  localparam int               OFF_W       = IDX_W + 2;

  logic [2:0]        dmode;
  logic [1:0]        ctl;
  logic              addr_hi_nz;
  logic              dm_bit;
  logic [TBL_AW-1:0] root_base;
  logic [OFF_W-1:0]  offset;
  logic              unused_cls;

  assign dmode      = msi_data[DMODE_LSB+2:DMODE_LSB];
  assign ctl        = dte2[W2_CTL_LSB+1:W2_CTL_LSB];
  assign addr_hi_nz = |msi_addr[MSI_AW-1:32];
  assign dm_bit     = msi_addr[ADDR_DM_BIT];

  assign eff_rid = (rid == INVALID_RID) ? IOAPIC_RID : rid;

  assign root_base  = {dte2[W2_ROOT_MSB:W2_ROOT_LSB], {W2_ROOT_LSB{1'b0}}};
  assign offset     = {msi_data[IDX_W-1:0], 2'b00};
  assign entry_addr = root_base + TBL_AW'(offset);

  // Per-type pass check shared by NMI, INIT and ExtINT
  function automatic action_e gate(input logic pass_bit, input logic dmb);
    return (pass_bit && !dmb) ? ACT_PASS : ACT_ERROR;
  endfunction

  always_comb begin
    action = ACT_PASS;
    if (!table_present || !dte2[W2_EN_BIT]) begin
      action = ACT_PASS;
    end else if (!remap_global_en) begin
      action = ACT_ERROR;
    end else if (addr_hi_nz) begin
      action = ACT_ERROR;
    end else begin
      case (dmode)
        DM_FIXED, DM_ARB: begin
          case (ctl)
            CTL_ABORT: action = ACT_ABORT;
            CTL_PASS:  action = ACT_PASS;
            CTL_REMAP: action = ACT_FETCH;
            default:   action = ACT_ERROR;
          endcase
        end
        DM_NMI:    action = gate(dte3[W3_NMI_BIT], dm_bit);
        DM_INIT:   action = gate(dte3[W3_INIT_BIT], dm_bit);
        DM_EXTINT: action = gate(dte3[W3_EXTINT_BIT], dm_bit);
        DM_SMI:    action = ACT_ERROR;
        default:   action = ACT_ERROR;
      endcase
    end
  end

  assign unused_cls = ^{msi_data[MSI_DW-1:IDX_W], dte2[DTE_W-1:TBL_AW],
                        dte2[W2_ROOT_LSB-1:W2_CTL_LSB+2],
                        dte3[DTE_W-1:W3_NMI_BIT+1],
                        msi_addr[31:ADDR_DM_BIT+1], msi_addr[ADDR_DM_BIT-1:0]};

endmodule

// File: rtl/msi_remap_entry_decode.sv
module msi_remap_entry_decode
  import msi_remap_pkg::*;
(
  input  logic [ENT_W-1:0]  entry_word,
  input  logic              rd_err,
  output rsp_status_e       status,
  output logic [MSI_AW-1:0] out_addr,
  output logic [MSI_DW-1:0] out_data
);

  entry_t ent;
  logic   unused_ent;

  assign ent = entry_t'(entry_word);

  always_comb begin
    if (rd_err)                status = ST_ERROR;
    else if (!ent.valid)       status = ST_ABORT;
    else if (ent.guest)        status = ST_ERROR;
    else if (ent.itype > DM_ARB) status = ST_ERROR;
    else                       status = ST_OK;
  end

  always_comb begin
    out_addr = '0;
    out_data = '0;
    if (status == ST_OK) begin
      out_addr[31:20]                      = MSI_WINDOW;
      out_addr[ADDR_DST_LSB+7:ADDR_DST_LSB] = ent.dest;
      out_addr[ADDR_RH_BIT]                = ent.redir;
      out_addr[ADDR_DM_BIT]                = ent.dest_mode;
      out_data[7:0]                        = ent.vector;
      out_data[DMODE_LSB+2:DMODE_LSB]      = ent.itype;
    end
  end

  assign unused_ent = ^{ent.rsvd_hi, ent.rsvd_lo};

endmodule

// File: rtl/msi_remap_unit.sv
module msi_remap_unit
  import msi_remap_pkg::*;
#(
  parameter int               RID_W      = 16,
  parameter int               IDX_W      = 11,
  parameter logic [RID_W-1:0] IOAPIC_RID = 16'h00A0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  input  logic [31:0]       req_data,
  input  logic [RID_W-1:0]  req_rid,
  input  logic [63:0]       dte_w2,
  input  logic [63:0]       dte_w3,
  input  logic              table_present,
  input  logic              remap_global_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [TBL_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              rsp_valid,
  output logic [63:0]       rsp_addr,
  output logic [31:0]       rsp_data,
  output logic [RID_W-1:0]  rsp_rid,
  output logic [1:0]        rsp_status
);

  localparam logic [RID_W-1:0] INVALID_RID = '1;

  state_e            state;
  action_e           c_action;
  logic [RID_W-1:0]  c_rid;
  logic [TBL_AW-1:0] c_entry_addr;
  rsp_status_e       d_status;
  logic [63:0]       d_addr;
  logic [31:0]       d_data;

  logic [63:0]       raw_addr_q;
  logic [31:0]       raw_data_q;
  logic [RID_W-1:0]  raw_rid_q;
  logic [TBL_AW-1:0] entry_addr_q;
  logic [63:0]       out_addr_q;
  logic [31:0]       out_data_q;
  logic [RID_W-1:0]  out_rid_q;
  rsp_status_e       out_status_q;
  logic              remapped_q;

  msi_remap_classify #(
    .RID_W      (RID_W),
    .IDX_W      (IDX_W),
    .IOAPIC_RID (IOAPIC_RID)
  ) u_classify (
    .msi_addr        (req_addr),
    .msi_data        (req_data),
    .rid             (req_rid),
    .dte2            (dte_w2),
    .dte3            (dte_w3),
    .table_present   (table_present),
    .remap_global_en (remap_global_en),
    .action          (c_action),
    .eff_rid         (c_rid),
    .entry_addr      (c_entry_addr)
  );

  msi_remap_entry_decode u_decode (
    .entry_word (mem_rsp_data),
    .rd_err     (mem_rsp_err),
    .status     (d_status),
    .out_addr   (d_addr),
    .out_data   (d_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      raw_addr_q   <= '0;
      raw_data_q   <= '0;
      raw_rid_q    <= '0;
      entry_addr_q <= '0;
      out_addr_q   <= '0;
      out_data_q   <= '0;
      out_rid_q    <= '0;
      out_status_q <= ST_OK;
      remapped_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            raw_addr_q   <= req_addr;
            raw_data_q   <= req_data;
            raw_rid_q    <= req_rid;
            out_rid_q    <= c_rid;
            entry_addr_q <= c_entry_addr;
            remapped_q   <= 1'b0;
            out_addr_q   <= '0;
            out_data_q   <= '0;
            case (c_action)
              ACT_PASS: begin
                out_addr_q   <= req_addr;
                out_data_q   <= req_data;
                out_status_q <= ST_OK;
                state        <= S_DONE;
              end
              ACT_FETCH: state <= S_RD_REQ;
              ACT_ABORT: begin
                out_status_q <= ST_ABORT;
                state        <= S_DONE;
              end
              default: begin
                out_status_q <= ST_ERROR;
                state        <= S_DONE;
              end
            endcase
          end
        end
        S_RD_REQ: begin
          if (mem_req_ready) state <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (mem_rsp_valid) begin
            out_addr_q   <= d_addr;
            out_data_q   <= d_data;
            out_status_q <= d_status;
            remapped_q   <= (d_status == ST_OK);
            state        <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_RD_REQ);
  assign mem_req_addr  = entry_addr_q;
  assign rsp_valid     = (state == S_DONE);
  assign rsp_addr      = out_addr_q;
  assign rsp_data      = out_data_q;
  assign rsp_rid       = out_rid_q;
  assign rsp_status    = out_status_q;

  // R12: one response pulse per accepted request
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7: read address holds while the read is not yet accepted
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R11: rejected requests carry a zero message
  p_fail_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_addr == '0 && rsp_data == '0));

  // R2: an ok response that was not remapped carries the request unchanged
  p_pass_copy_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd0 && !remapped_q)
      |-> (rsp_addr == raw_addr_q && rsp_data == raw_data_q));

  // R9: remapped addresses land in the interrupt window
  p_remap_window_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && remapped_q) |-> (rsp_addr[63:20] == {32'h0, MSI_WINDOW}));

  // R4: a remapped result never comes from a request with a high address
  p_hi_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && remapped_q) |-> (raw_addr_q[63:32] == 32'h0));

  // R1: invalid requester ID is replaced
  p_rid_sub_r1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && raw_rid_q == INVALID_RID) |-> (rsp_rid == IOAPIC_RID));

  // R8: status code 3 is never produced
  p_status_legal_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status != 2'd3));

endmodule

// File: tb/msi_remap_unit_bench.sv
`timescale 1ns/1ps
module msi_remap_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_addr;
  logic [31:0] req_data;
  logic [15:0] req_rid;
  logic [63:0] dte_w2;
  logic [63:0] dte_w3;
  logic        table_present;
  logic        remap_global_en;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        mem_rsp_err;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_data;
  logic [15:0] rsp_rid;
  logic [1:0]  rsp_status;

  always #2 clk = ~clk;

  msi_remap_unit u_msi_remap_unit (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_rid(req_rid),
    .dte_w2(dte_w2), .dte_w3(dte_w3),
    .table_present(table_present), .remap_global_en(remap_global_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .rsp_rid(rsp_rid), .rsp_status(rsp_status)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic [15:0] rid;
    logic [63:0] w2;
    logic [63:0] w3;
    logic        devtab;
    logic        glob;
    logic [31:0] entry;
    logic        merr;
    logic [1:0]  st;
    logic        fetch;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] A0    = 64'h0000_0000_FEE0_1000;
  localparam logic [63:0] ADM   = 64'h0000_0000_FEE0_1004;
  localparam logic [63:0] AHI   = 64'h0000_0001_FEE0_1000;
  localparam logic [63:0] ROOT  = 64'h0000_00AB_CDE0_0000;
  localparam logic [63:0] W2R   = ROOT | 64'h5;
  localparam logic [63:0] W2P   = ROOT | 64'h3;
  localparam logic [63:0] W2A   = ROOT | 64'h1;
  localparam logic [63:0] W2X   = ROOT | 64'h7;
  localparam logic [63:0] W2OFF = ROOT | 64'h4;
  localparam logic [15:0] RID   = 16'h0108;
  localparam logic [31:0] E_OK  = 32'h0041_3C61;
  localparam logic [31:0] E_ARB = 32'h009A_0705;
  localparam logic [31:0] E_INV = 32'h0041_3C60;
  localparam logic [31:0] E_GM  = 32'h0041_3CE1;
  localparam logic [31:0] E_TY  = 32'h0041_3C69;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{A0,  32'h005, RID,      W2R,   64'h0, 1'b0, 1'b1, E_OK,  1'b0, 2'd0, 1'b0, 8'd2},  // R2 no table
    '{A0,  32'h005, RID,      W2OFF, 64'h0, 1'b1, 1'b1, E_OK,  1'b0, 2'd0, 1'b0, 8'd2},  // R2 enable clear
    '{A0,  32'h005, RID,      W2R,   64'h0, 1'b1, 1'b0, E_OK,  1'b0, 2'd2, 1'b0, 8'd3},  // R3
    '{AHI, 32'h005, RID,      W2R,   64'h0, 1'b1, 1'b1, E_OK,  1'b0, 2'd2, 1'b0, 8'd4},  // R4
    '{AHI, 32'h005, RID,      W2OFF, 64'h0, 1'b1, 1'b1, E_OK,  1'b0, 2'd0, 1'b0, 8'd4},  // R4 disabled wins
    '{A0,  32'h005, RID,      W2P,   64'h0, 1'b1, 1'b1, E_OK,  1'b0, 2'd0, 1'b0, 8'd6},  // R6 pass
    '{A0,  32'h005, RID,      W2A,   64'h0, 1'b1, 1'b1, E_OK,  1'b0, 2'd1, 1'b0, 8'd6},  // R6 abort
    '{A0,  32'h005, RID,      W2X,   64'h0, 1'b1, 1'b1, E_OK,  1'b0, 2'd2, 1'b0, 8'd6},  // R6 reserved
    '{A0,  32'h005, RID,      W2R,   64'h0, 1'b1, 1'b1, E_OK,  1'b0, 2'd0, 1'b1, 8'd9},  // R9 fixed
    '{A0,  32'h123, RID,      W2R,   64'h0, 1'b1, 1'b1, E_ARB, 1'b0, 2'd0, 1'b1, 8'd9},  // R9 arbitrated
    '{A0,  32'h005, RID,      W2R,   64'h0, 1'b1, 1'b1, E_INV, 1'b0, 2'd1, 1'b1, 8'd8},  // R8 invalid
    '{A0,  32'h005, RID,      W2R,   64'h0, 1'b1, 1'b1, E_GM,  1'b0, 2'd2, 1'b1, 8'd8},  // R8 guest
    '{A0,  32'h005, RID,      W2R,   64'h0, 1'b1, 1'b1, E_TY,  1'b0, 2'd2, 1'b1, 8'd8},  // R8 type
    '{A0,  32'h005, RID,      W2R,   64'h0, 1'b1, 1'b1, E_OK,  1'b1, 2'd2, 1'b1, 8'd8},  // R8 mem error
    '{A0,  32'h200, RID,      W2R,   64'h7, 1'b1, 1'b1, E_OK,  1'b0, 2'd2, 1'b0, 8'd5},  // R5 SMI
    '{A0,  32'h300, RID,      W2R,   64'h7, 1'b1, 1'b1, E_OK,  1'b0, 2'd2, 1'b0, 8'd5},  // R5 mode 3
    '{A0,  32'h600, RID,      W2R,   64'h7, 1'b1, 1'b1, E_OK,  1'b0, 2'd2, 1'b0, 8'd5},  // R5 mode 6
    '{A0,  32'h402, RID,      W2A,   64'h4, 1'b1, 1'b1, E_OK,  1'b0, 2'd0, 1'b0, 8'd10}, // R10 NMI
    '{A0,  32'h500, RID,      W2R,   64'h1, 1'b1, 1'b1, E_OK,  1'b0, 2'd0, 1'b0, 8'd10}, // R10 INIT
    '{A0,  32'h700, RID,      W2R,   64'h2, 1'b1, 1'b1, E_OK,  1'b0, 2'd0, 1'b0, 8'd10}, // R10 ExtINT
    '{A0,  32'h402, RID,      W2R,   64'h3, 1'b1, 1'b1, E_OK,  1'b0, 2'd2, 1'b0, 8'd10}, // R10 no NMI bit
    '{ADM, 32'h500, RID,      W2R,   64'h7, 1'b1, 1'b1, E_OK,  1'b0, 2'd2, 1'b0, 8'd10}, // R10 dest mode
    '{A0,  32'h005, 16'hFFFF, W2P,   64'h0, 1'b1, 1'b1, E_OK,  1'b0, 2'd0, 1'b0, 8'd1},  // R1 pass
    '{AHI, 32'h005, 16'hFFFF, W2R,   64'h0, 1'b1, 1'b1, E_OK,  1'b0, 2'd2, 1'b0, 8'd1}   // R1 error
  };

  function automatic logic [63:0] exp_addr(input vec_t v);
    if (v.st != 2'd0) return 64'h0;
    if (!v.fetch)     return v.addr;
    return 64'hFEE0_0000 | {40'h0, v.entry[15:8], 12'h0}
         | (64'(v.entry[5]) << 3) | (64'(v.entry[6]) << 2);
  endfunction

  function automatic logic [31:0] exp_data(input vec_t v);
    if (v.st != 2'd0) return 32'h0;
    if (!v.fetch)     return v.data;
    return {21'h0, v.entry[4:2], v.entry[23:16]};
  endfunction

  function automatic logic [15:0] exp_rid(input logic [15:0] r);
    return (r == 16'hFFFF) ? 16'h00A0 : r;
  endfunction

  function automatic logic [51:0] exp_rd_addr(input vec_t v);
    return {v.w2[51:6], 6'b0} + 52'({v.data[10:0], 2'b00});
  endfunction

  task automatic drive(input vec_t v);
    req_addr        = v.addr;
    req_data        = v.data;
    req_rid         = v.rid;
    dte_w2          = v.w2;
    dte_w3          = v.w3;
    table_present   = v.devtab;
    remap_global_en = v.glob;
  endtask

  task automatic check_rsp(input vec_t v, input string tag);
    chk(rsp_status == v.st, tag, "status", 64'(rsp_status), 64'(v.st));
    chk(rsp_addr == exp_addr(v), tag, "addr", rsp_addr, exp_addr(v));
    chk(rsp_data == exp_data(v), tag, "data", 64'(rsp_data), 64'(exp_data(v)));
    chk(rsp_rid == exp_rid(v.rid), tag, "rid R1", 64'(rsp_rid), 64'(exp_rid(v.rid)));
  endtask

  task automatic run_one(input vec_t v, input int stall);
    string tag = $sformatf("R%0d", v.req);
    int          reads = 0;
    logic [51:0] seen  = '0;
    bit          pend  = 0;
    bit          got   = 0;
    @(negedge clk);
    drive(v);
    req_valid     = 1'b1;
    mem_req_ready = (stall == 0);
    for (int c = 0; c < 60 && !got; c++) begin
      @(negedge clk);
      req_valid     = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (rsp_valid) begin
        got = 1;
        check_rsp(v, tag);
      end else begin
        if (pend) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = v.entry;
          mem_rsp_err   = v.merr;
          pend = 0;
        end
        if (mem_req_valid) begin
          if (reads == 0) begin
            reads = 1;
            seen  = mem_req_addr;
            chk(!req_ready, "R12", "ready while busy", 64'(req_ready), 64'h0);
          end else begin
            chk(mem_req_addr == seen, "R7", "addr held", 64'(mem_req_addr), 64'(seen));
          end
          if (stall > 0) stall--;
          if (stall == 0) begin
            mem_req_ready = 1'b1;
            pend = 1;
          end
        end
      end
    end
    chk(got, tag, "response seen", 64'(got), 64'h1);
    chk(reads == int'(v.fetch), "R7", "read count", 64'(reads), 64'(v.fetch));
    if (v.fetch)
      chk(seen == exp_rd_addr(v), "R7", "read addr", 64'(seen), 64'(exp_rd_addr(v)));
    @(negedge clk);
    chk(!rsp_valid, "R12", "pulse ends", 64'(rsp_valid), 64'h0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0;
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    mem_rsp_err = 1'b0;
    drive(VECS[0]);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state (R12)
    chk(req_ready, "R12", "reset ready", 64'(req_ready), 64'h1);
    chk(!rsp_valid, "R12", "reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(!mem_req_valid, "R7", "reset mem_req_valid", 64'(mem_req_valid), 64'h0);

    // Vector table
    for (int i = 0; i < NV; i++) run_one(VECS[i], 0);

    // R7: stalled read, address must stay put
    run_one(VECS[8], 3);
    run_one(VECS[9], 1);

    // R12: new request waiting while a response is issued
    @(negedge clk);
    drive(VECS[5]);
    req_valid = 1'b1;
    @(negedge clk);
    chk(rsp_valid, "R12", "first rsp", 64'(rsp_valid), 64'h1);
    check_rsp(VECS[5], "R12");
    chk(!req_ready, "R12", "ready during rsp", 64'(req_ready), 64'h0);
    drive(VECS[22]);
    @(negedge clk);
    chk(!rsp_valid, "R12", "gap after rsp", 64'(rsp_valid), 64'h0);
    chk(req_ready, "R12", "idle again", 64'(req_ready), 64'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid, "R12", "second rsp", 64'(rsp_valid), 64'h1);
    check_rsp(VECS[22], "R1");
    @(negedge clk);
    chk(!rsp_valid, "R12", "single pulse", 64'(rsp_valid), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule